// File: doc/BRIEF.md
# Two-Line Pulse Packet Receiver

This block recovers a fixed-length command packet that a host sends by toggling two shared select lines of a keypad port. The CPU writes a 2-bit line state into the port. Each write is presented to the receiver as a one-cycle strobe with the new state. The lines carry no clock and no data. Each bit is coded in the order of the level patterns:

- both lines low is a reset pulse;
- one line low marks a one, the other line low marks a zero;
- both lines high advances to the next bit.

Bits are collected least significant first into a 128-bit buffer. A stop pattern then raises a one-cycle packet-valid strobe while the buffer is presented on the data output.

Once a packet has been delivered, the host reuses the same two lines for a three-step handshake. This handshake rotates a multiplayer controller index. The index is wrapped by a controller-count mask supplied on an input port; the allowed mask values are 0, 1 and 3. The meaning of the packet contents and the keypad readout belong to other blocks.

Top module: `pulse_pkt_rx`

## Requirements
- R1: After reset, `pkt_valid` is 0, `pkt_data` is all zero and `ctrl_idx` is 0. The internal bit position starts at "no data yet" (-1), and the remembered line state starts at 2'b11.
- R2: A write of state 2'b00 clears `pkt_data` to zero and returns the bit position to "no data yet". This happens even when the previous write was also 2'b00.
- R3: Any other write whose state equals the previously written state has no effect at all.
- R4: While the bit position p is 0..127, a write of 2'b01 sets `pkt_data[p]`, which is bit p%8 of byte p/8. While p is -1, state 2'b01 records nothing. Bits already set are only removed by 2'b00.
- R5: While p is below 128, a write of 2'b11 increments p by one. A write of 2'b10 records nothing, so that bit stays 0.
- R6: With p equal to 128, a write of 2'b10 makes `pkt_valid` high for exactly the one cycle after the write edge. `pkt_data` then holds the packet, and p moves to 129. At p = 128, states 2'b01 and 2'b11 do nothing.
- R7: With p above 128:
  - 2'b01 sets bit 1 of p;
  - 2'b10 sets bit 2 of p;
  - 2'b11 with p exactly 135 returns p to 129 and sets `ctrl_idx` to (`ctrl_idx` + 1) AND `ctrl_mask`, visible after the write edge.
- R8: `ctrl_idx` changes only on that rotation step. In particular, 2'b11 at p above 128 but not 135 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_we | input | 1 | One-cycle strobe: CPU wrote the select lines |
| line_state | input | 2 | Written select-line state |
| ctrl_mask | input | 2 | Controller-count mask (0, 1 or 3) |
| pkt_valid | output | 1 | One-cycle packet delivery strobe |
| pkt_data | output | 128 | Packet buffer, bit 0 received first |
| ctrl_idx | output | 2 | Current controller index |

## Verification
The bit position is internal, so errors in it surface only indirectly:
- A bit position that is off by one shows up at the very next 2'b01 write, as a data bit landing in the wrong place.
- An error in the stop or rotation thresholds appears only at the end of a full packet, as a missing or early `pkt_valid` pulse or a stalled `ctrl_idx`.

The `pkt_data`, `pkt_valid` and `ctrl_idx` outputs are therefore compared after every single write. This catches such faults within one write of their cause.

// File: rtl/pprx_pkg.sv
`timescale 1ns/1ps
package pprx_pkg;
   typedef enum logic [1:0] {
      LN_CLR  = 2'b00,
      LN_ONE  = 2'b01,
      LN_ZERO = 2'b10,
      LN_STEP = 2'b11
   } line_e;
endpackage

// File: rtl/pprx_seq.sv
`timescale 1ns/1ps
module pprx_seq
   import pprx_pkg::*;
#(
   parameter int PKT_BITS = 128,
   parameter int CNT_W    = 9,
   localparam int BIT_IW  = $clog2(PKT_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        st,
   output logic              clr,
   output logic              set_en,
   output logic [BIT_IW-1:0] set_idx,
   output logic              deliver,
   output logic              rotate
);
   localparam logic signed [CNT_W-1:0] C_IDLE = -1;
   localparam logic signed [CNT_W-1:0] C_END  = CNT_W'(PKT_BITS);
   localparam logic signed [CNT_W-1:0] C_POST = CNT_W'(PKT_BITS + 1);
   localparam logic signed [CNT_W-1:0] C_ROT  = CNT_W'(PKT_BITS + 7);
   localparam logic signed [CNT_W-1:0] K_B1   = 2;
   localparam logic signed [CNT_W-1:0] K_B2   = 4;

   logic signed [CNT_W-1:0] pos, pos_n;
   logic [1:0]              last, last_n;

   always_comb begin
      pos_n   = pos;
      last_n  = last;
      clr     = 1'b0;
      set_en  = 1'b0;
      deliver = 1'b0;
      rotate  = 1'b0;
      if (we) begin
         if (st == LN_CLR) begin
            clr   = 1'b1;
            pos_n = C_IDLE;
         end
         if (st != last) begin
            last_n = st;
            if (pos > C_END) begin
               case (st)
                  LN_ONE:  pos_n = pos | K_B1;
                  LN_ZERO: pos_n = pos | K_B2;
                  LN_STEP: if (pos == C_ROT) begin
                     pos_n  = pos & ~(K_B1 | K_B2);
                     rotate = 1'b1;
                  end
                  default: ;
               endcase
            end else if (pos == C_END) begin
               if (st == LN_ZERO) begin
                  deliver = 1'b1;
                  pos_n   = C_POST;
               end
            end else begin
               if (st == LN_ONE && !pos[CNT_W-1]) set_en = 1'b1;
               if (st == LN_STEP) pos_n = pos + 1'b1;
            end
         end
      end
   end

   assign set_idx = pos[BIT_IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos  <= C_IDLE;
         last <= LN_STEP;
      end else begin
         pos  <= pos_n;
         last <= last_n;
      end
   end

   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (pos >= C_IDLE) && (pos <= C_ROT)); // R5
   AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && st == LN_CLR) |=> (pos == C_IDLE)); // R2
   AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && st == last && st != LN_CLR) |=> $stable(pos)); // R3
   AST_DELIVER_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      deliver |=> (pos == C_POST) && !deliver); // R6
endmodule

// File: rtl/pprx_buf.sv
`timescale 1ns/1ps
module pprx_buf #(
   parameter int PKT_BITS = 128,
   localparam int BIT_IW  = $clog2(PKT_BITS),
   localparam int NBYTES  = PKT_BITS / 8,
   localparam int BYTE_IW = BIT_IW - 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                set_en,
   input  logic [BIT_IW-1:0]   set_idx,
   output logic [PKT_BITS-1:0] data
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic [7:0] q;
      logic       hit;
      assign hit = set_en && (set_idx[BIT_IW-1:3] == BYTE_IW'(b));
      always_ff @(posedge clk) begin
         if (!rst_n)   q <= '0;
         else if (clr) q <= '0;
         else if (hit) q[set_idx[2:0]] <= 1'b1;
      end
      assign data[b*8 +: 8] = q;
   end

   AST_BUF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (data == '0)); // R2
   AST_BUF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (($past(data) & ~data) == '0)); // R4
endmodule

// File: rtl/pprx_ctrl.sv
`timescale 1ns/1ps
module pprx_ctrl #(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [IDX_W-1:0] mask,
   output logic [IDX_W-1:0] idx
);
   always_ff @(posedge clk) begin
      if (!rst_n)   idx <= '0;
      else if (adv) idx <= (idx + 1'b1) & mask;
   end

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(idx)); // R8
endmodule

// File: rtl/pulse_pkt_rx.sv
`timescale 1ns/1ps
module pulse_pkt_rx #(
   parameter int PKT_BITS = 128,
   parameter int IDX_W    = 2,
   parameter int CNT_W    = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_we,
   input  logic [1:0]          line_state,
   input  logic [IDX_W-1:0]    ctrl_mask,
   output logic                pkt_valid,
   output logic [PKT_BITS-1:0] pkt_data,
   output logic [IDX_W-1:0]    ctrl_idx
);
   localparam int BIT_IW = $clog2(PKT_BITS);

   if (PKT_BITS < 16 || (PKT_BITS % 8) != 0 || (1 << BIT_IW) != PKT_BITS) begin : g_bad_bits
      $error("PKT_BITS must be a power of two of at least 16");
   end
   if (CNT_W < BIT_IW + 2) begin : g_bad_cnt
      $error("CNT_W too narrow for PKT_BITS+7 as a signed value");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end

   logic              clr, set_en, deliver, rotate;
   logic [BIT_IW-1:0] set_idx;

   pprx_seq #(.PKT_BITS(PKT_BITS), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .we(line_we), .st(line_state),
      .clr(clr), .set_en(set_en), .set_idx(set_idx),
      .deliver(deliver), .rotate(rotate));

   pprx_buf #(.PKT_BITS(PKT_BITS)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(clr), .set_en(set_en),
      .set_idx(set_idx), .data(pkt_data));

   pprx_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .adv(rotate), .mask(ctrl_mask), .idx(ctrl_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) pkt_valid <= 1'b0;
      else        pkt_valid <= deliver;
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> !pkt_valid); // R6
   AST_NO_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !line_we |=> !pkt_valid); // R6
endmodule

// File: tb/sim_pulse_pkt_rx.sv
`timescale 1ns/1ps
module sim_pulse_pkt_rx;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         line_we = 1'b0;
   logic [1:0]   line_state = 2'b11;
   logic [1:0]   ctrl_mask = 2'b11;
   logic         pkt_valid;
   logic [127:0] pkt_data;
   logic [1:0]   ctrl_idx;

   int n_chk = 0;
   int n_bad = 0;

   int           m_cnt;
   logic [127:0] m_buf;
   logic [1:0]   m_last;
   logic [1:0]   m_idx;
   bit           m_dv;

   always #10 clk = ~clk;

   pulse_pkt_rx u0 (
      .clk(clk), .rst_n(rst_n), .line_we(line_we), .line_state(line_state),
      .ctrl_mask(ctrl_mask), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .ctrl_idx(ctrl_idx));

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic m_apply(input logic [1:0] s, input logic [1:0] msk);
      m_dv = 1'b0;
      if (s == 2'b00) begin
         m_cnt = -1;
         m_buf = '0;
      end
      if (s == m_last) return;
      m_last = s;
      if (m_cnt > 128) begin
         if (s == 2'b01) m_cnt = m_cnt | 2;
         else if (s == 2'b10) m_cnt = m_cnt | 4;
         else if (s == 2'b11 && m_cnt == 135) begin
            m_cnt = m_cnt & ~6;
            m_idx = (m_idx + 2'd1) & msk;
         end
      end else if (m_cnt == 128) begin
         if (s == 2'b10) begin
            m_dv  = 1'b1;
            m_cnt = 129;
         end
      end else begin
         if (s == 2'b01 && m_cnt >= 0) m_buf[m_cnt] = 1'b1;
         if (s == 2'b11) m_cnt++;
      end
   endtask

   task automatic wr(input logic [1:0] s);
      @(negedge clk);
      line_we    = 1'b1;
      line_state = s;
      @(posedge clk);
      m_apply(s, ctrl_mask);
      #5;
      chk((s == 2'b00) ? "R2 data" : "R4 data", pkt_data, m_buf);
      chk("R6 valid", {127'd0, pkt_valid}, {127'd0, m_dv});
      chk("R7/R8 idx", {126'd0, ctrl_idx}, {126'd0, m_idx});
      @(negedge clk);
      line_we = 1'b0;
   endtask

   task automatic send_pkt(input logic [127:0] p, input bit dup);
      wr(2'b00);
      wr(2'b11);
      for (int i = 0; i < 128; i++) begin
         wr(p[i] ? 2'b01 : 2'b10);
         if (dup && $urandom_range(0, 3) == 0) wr(p[i] ? 2'b01 : 2'b10);
         wr(2'b11);
      end
      wr(2'b10);
   endtask

   task automatic rotate3;
      wr(2'b01);
      wr(2'b10);
      wr(2'b11);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [127:0] pat;
      void'($urandom(32'h1F2E3D4C));
      m_cnt = -1; m_buf = '0; m_last = 2'b11; m_idx = 2'b00; m_dv = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 data", pkt_data, '0);
      chk("R1 valid", {127'd0, pkt_valid}, 128'd0);
      chk("R1 idx", {126'd0, ctrl_idx}, 128'd0);

      // R4: state 01 ignored while position is -1
      wr(2'b00); wr(2'b01);
      chk("R4 no-data", pkt_data, '0);
      // R3: repeated 11 does not advance; bit lands at position 0
      wr(2'b11); wr(2'b11); wr(2'b01);
      chk("R3 repeat", pkt_data, 128'h1);
      // R5: 10 records nothing, 11 steps to position 1, 2
      wr(2'b11); wr(2'b10); wr(2'b11); wr(2'b01);
      chk("R5 step", pkt_data, 128'h5);
      // R2: repeated 00 still clears
      wr(2'b00); wr(2'b00);
      chk("R2 clear", pkt_data, '0);

      // R6 full packet, fixed pattern
      pat = 128'hA5C3_0F1E_8000_0001_DEAD_BEEF_1234_5678;
      send_pkt(pat, 1'b0);
      chk("R6 payload", pkt_data, pat);
      // extra 10/01/11 at 129..: R7 and no second pulse
      ctrl_mask = 2'b11;
      for (int k = 0; k < 5; k++) rotate3();
      chk("R7 wrap mask3", {126'd0, ctrl_idx}, 128'd1);
      // R8: incomplete handshake leaves index
      wr(2'b01); wr(2'b11);
      chk("R8 partial", {126'd0, ctrl_idx}, 128'd1);
      wr(2'b10); wr(2'b11);
      chk("R7 completes", {126'd0, ctrl_idx}, 128'd2);
      ctrl_mask = 2'b01;
      rotate3();
      chk("R7 mask1", {126'd0, ctrl_idx}, 128'd1);
      ctrl_mask = 2'b00;
      rotate3();
      chk("R7 mask0", {126'd0, ctrl_idx}, 128'd0);

      // random packets with occasional repeated writes
      for (int n = 0; n < 12; n++) begin
         case ($urandom_range(0, 2))
            0: ctrl_mask = 2'b00;
            1: ctrl_mask = 2'b01;
            default: ctrl_mask = 2'b11;
         endcase
         pat = {$urandom, $urandom, $urandom, $urandom};
         send_pkt(pat, 1'b1);
         chk("R6 random payload", pkt_data, pat);
         repeat ($urandom_range(0, 3)) rotate3();
      end
      // random line states
      for (int n = 0; n < 3000; n++) begin
         wr(2'($urandom_range(0, 15) == 0 ? 0 : $urandom_range(1, 3)));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule